// File: doc/BRIEF.md
# Configurable programmable logic array

This block is a small programmable sum-of-products array. It has two programmable planes. The first, the product plane, builds each product term from any mix of the true and inverted forms of the inputs. The second, the sum plane, attaches any product term to any output. One term can therefore feed several outputs at once. Each output then passes through an exclusive-OR with a programmable polarity bit. When that bit is set, the output is the complement of its sum, which makes product-of-sums functions possible.

The configuration arrives as a serial bit stream. A shift strobe clocks one bit into a staging register. A load strobe copies the staging register into the active configuration in a single clock. While a new stream is being staged, the old configuration keeps driving the outputs. The last bit of the staging register is visible on a serial output, so shifting reads back what was staged.

The outputs are pure combinational functions of the current inputs and the active configuration. The default size is three inputs, four product terms and three outputs, which gives a 39-bit bitmap. All three counts are parameters, and the bitmap length is derived from them.

Top module: `pla_array`

## Requirements
- R1: After reset, both the staging register and the active configuration are zero. Every output reads 0 and `cfg_sout` reads 0 until a configuration is loaded.
- R2: On a clock with `cfg_shift` high, the staging register takes `cfg_sin` into its bit 0 and moves every other bit one place up. `cfg_sout` always shows the top bit (bit CFG_W-1), so the first bit shifted in leaves first (readback). With `cfg_shift` low the staging register holds its value.
- R3: On a clock with `cfg_load` high, the active configuration takes the content the staging register had before that edge, even when `cfg_shift` is also high in the same cycle. Outputs follow the new configuration from that edge on.
- R4: The bitmap is sent top bit first, with CFG_W = NT*2*NI + NO*NT + NO bits. The product rows come first, term 0 first; each row is 2*NI bits. Next come the sum rows, output 0 first; each row is NT bits. Last come the NO polarity bits. Within a product row, bit 2*i selects the true form of input i and bit 2*i+1 its inverted form. Within a sum row, bit t attaches term t. Polarity bit o is bitmap bit o.
- R5: A product term is 1 exactly when every literal selected in its row is true.
- R6: A product term with no selected literal evaluates to 0. So does a term that selects both forms of the same input.
- R7: Each output's sum is the OR of the terms attached to it, and one term may feed several outputs. An output with no attached term has a sum of 0.
- R8: Each output equals its sum XOR its polarity bit.
- R9: The outputs follow `x_in` combinationally within the same cycle, with no clock edge needed.
- R10: Without `cfg_load`, the active configuration and therefore the outputs are unaffected by shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_sin | input | 1 | Serial configuration data |
| cfg_shift | input | 1 | Shift one bit into the staging register |
| cfg_load | input | 1 | Copy the staging register into the active configuration |
| x_in | input | N_IN | Logic inputs |
| y_out | output | N_OUT | Logic outputs |
| cfg_sout | output | 1 | Top bit of the staging register (readback) |

## Verification
Loading and shifting can land on the same clock edge. The load must capture the staging content as it stood before that edge's shift. The bench provokes this by staging a full second configuration while the first one stays active. It then raises `cfg_load` together with `cfg_shift`, with a 1 on `cfg_sin`. A bitmap captured after the shift would be moved by one place and would alter every output, so the bench judges the result by comparing the outputs, over several input patterns, with a reference model that applies the load before the shift.

// File: rtl/pla_pkg.sv
// Package pla_pkg
// Shared sizing helpers for the programmable logic array.
// Assumes every count is at least 1.
package pla_pkg;

    // Width of one product-plane row: true and inverted literal per input.
    function automatic int prod_row_bits(input int n_in);
        return 2 * n_in;
    endfunction

    // Total width of the product plane.
    function automatic int prod_plane_bits(input int n_in, input int n_term);
        return n_term * prod_row_bits(n_in);
    endfunction

    // Total width of the sum plane.
    function automatic int sum_plane_bits(input int n_term, input int n_out);
        return n_out * n_term;
    endfunction

    // Full bitmap width: product plane, sum plane, polarity bits.
    function automatic int cfg_bits(input int n_in, input int n_term, input int n_out);
        return prod_plane_bits(n_in, n_term) + sum_plane_bits(n_term, n_out) + n_out;
    endfunction

endpackage

// File: rtl/pla_cfg_store.sv
// Module pla_cfg_store
// Holds the staging shift register and the active configuration register.
// A shift moves the serial bit into bit 0. A load copies the pre-edge
// staging content into the active register. Both registers clear on a
// synchronous active-low reset.
module pla_cfg_store #(
    parameter int W = 39
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sin,
    input  logic         shift_en,
    input  logic         load,
    output logic [W-1:0] stage_q,
    output logic [W-1:0] active_q,
    output logic         sout
);

    // Staging register: serial shift, top bit first out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (shift_en) begin
            stage_q <= {stage_q[W-2:0], sin};
        end
    end

    // Active register: takes the old staging content on a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= '0;
        end else if (load) begin
            active_q <= stage_q;
        end
    end

    // Readback of the staging register's oldest bit.
    always_comb begin
        sout = stage_q[W-1];
    end

endmodule

// File: rtl/pla_and_plane.sv
// Module pla_and_plane
// Forms NT product terms from the inputs. Row t sits at the top of cfg for
// t = 0. Row bit 2*i selects the true form of input i and row bit 2*i+1
// selects its inverted form. An empty row gives 0. Assumes cfg is stable
// while the terms are used.
module pla_and_plane #(
    parameter int NI = 3,
    parameter int NT = 4,
    parameter int RW = 2 * NI
) (
    input  logic [NT*RW-1:0] cfg,
    input  logic [NI-1:0]    x,
    output logic [NT-1:0]    term
);

    for (genvar t = 0; t < NT; t++) begin : g_term
        logic [RW-1:0] row;
        logic [NI-1:0] lit_ok;

        // Slice this term's row from the plane.
        always_comb begin
            row = cfg[(NT-1-t)*RW +: RW];
        end

        for (genvar i = 0; i < NI; i++) begin : g_lit
            // A selected literal must be true; an unselected one passes.
            always_comb begin
                lit_ok[i] = (~row[2*i] | x[i]) & (~row[2*i+1] | ~x[i]);
            end
        end

        // Product of all literal checks, forced low when the row is empty.
        always_comb begin
            term[t] = (|row) & (&lit_ok);
        end
    end

endmodule

// File: rtl/pla_or_plane.sv
// Module pla_or_plane
// Sums the attached product terms for each output and applies the
// programmable polarity. Row o sits at the top of cfg for o = 0; row bit t
// attaches term t. An output with no attached term sums to 0.
module pla_or_plane #(
    parameter int NT = 4,
    parameter int NO = 3
) (
    input  logic [NO*NT-1:0] cfg,
    input  logic [NO-1:0]    pol,
    input  logic [NT-1:0]    term,
    output logic [NO-1:0]    y
);

    for (genvar o = 0; o < NO; o++) begin : g_out
        logic [NT-1:0] row;
        logic          sum;

        // Slice this output's row from the plane.
        always_comb begin
            row = cfg[(NO-1-o)*NT +: NT];
        end

        // OR of the attached terms.
        always_comb begin
            sum = |(row & term);
        end

        // Polarity stage.
        always_comb begin
            y[o] = sum ^ pol[o];
        end
    end

endmodule

// File: rtl/pla_array.sv
// Module pla_array (top)
// Serially configured programmable logic array. The bitmap is sent top bit
// first: product rows, then sum rows, then polarity bits. Evaluation is
// combinational from x_in and the active configuration. Assumes cfg_load
// is raised only once a complete bitmap has been staged.
module pla_array #(
    parameter int N_IN   = 3,
    parameter int N_TERM = 4,
    parameter int N_OUT  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_sin,
    input  logic             cfg_shift,
    input  logic             cfg_load,
    input  logic [N_IN-1:0]  x_in,
    output logic [N_OUT-1:0] y_out,
    output logic             cfg_sout
);

    localparam int ROW_W  = pla_pkg::prod_row_bits(N_IN);
    localparam int PROD_W = pla_pkg::prod_plane_bits(N_IN, N_TERM);
    localparam int SUM_W  = pla_pkg::sum_plane_bits(N_TERM, N_OUT);
    localparam int CFG_W  = pla_pkg::cfg_bits(N_IN, N_TERM, N_OUT);

    logic [CFG_W-1:0]  stage_q;
    logic [CFG_W-1:0]  active_q;
    logic [PROD_W-1:0] prod_cfg;
    logic [SUM_W-1:0]  sum_cfg;
    logic [N_OUT-1:0]  pol_cfg;
    logic [N_TERM-1:0] term;

    pla_cfg_store #(
        .W (CFG_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .sin      (cfg_sin),
        .shift_en (cfg_shift),
        .load     (cfg_load),
        .stage_q  (stage_q),
        .active_q (active_q),
        .sout     (cfg_sout)
    );

    // Split the active bitmap into its three fields.
    always_comb begin
        prod_cfg = active_q[CFG_W-1 -: PROD_W];
        sum_cfg  = active_q[N_OUT +: SUM_W];
        pol_cfg  = active_q[N_OUT-1:0];
    end

    pla_and_plane #(
        .NI (N_IN),
        .NT (N_TERM),
        .RW (ROW_W)
    ) u_and (
        .cfg  (prod_cfg),
        .x    (x_in),
        .term (term)
    );

    pla_or_plane #(
        .NT (N_TERM),
        .NO (N_OUT)
    ) u_or (
        .cfg  (sum_cfg),
        .pol  (pol_cfg),
        .term (term),
        .y    (y_out)
    );

endmodule

// File: rtl/pla_array_chk.sv
// Module pla_array_chk
// Clocked checks on the configuration path and outputs of pla_array,
// attached with a bind. Assumes the synchronous active-low reset.
module pla_array_chk #(
    parameter int W  = 39,
    parameter int NT = 4,
    parameter int NO = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_shift,
    input logic          cfg_load,
    input logic          cfg_sout,
    input logic [NO-1:0] y_out,
    input logic [W-1:0]  stage_q,
    input logic [W-1:0]  active_q
);

    logic loaded_seen;

    // Remembers whether any load has happened since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loaded_seen <= 1'b0;
        end else if (cfg_load) begin
            loaded_seen <= 1'b1;
        end
    end

    assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !loaded_seen |-> (y_out == '0));

    assert_shift_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_shift |=> (cfg_sout == $past(stage_q[W-2])));

    assert_shift_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_shift |=> $stable(cfg_sout));

    assert_load_old_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> (active_q == $past(stage_q)));

    assert_no_load_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> $stable(active_q));

    assert_empty_sum_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q[NO +: NO*NT] == '0) |-> (y_out == active_q[NO-1:0]));

endmodule

bind pla_array pla_array_chk #(
    .W  (CFG_W),
    .NT (N_TERM),
    .NO (N_OUT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_shift (cfg_shift),
    .cfg_load  (cfg_load),
    .cfg_sout  (cfg_sout),
    .y_out     (y_out),
    .stage_q   (stage_q),
    .active_q  (active_q)
);

// File: tb/pla_array_tb.sv
`timescale 1ns/1ps
module pla_array_tb;
    localparam int NI = 3;
    localparam int NT = 4;
    localparam int NO = 3;
    localparam int AW = 2 * NI;
    localparam int W  = NT * AW + NO * NT + NO;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_sin = 1'b0;
    logic cfg_shift = 1'b0;
    logic cfg_load = 1'b0;
    logic [NI-1:0] x_in = '0;
    logic [NO-1:0] y_out;
    logic cfg_sout;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    pla_array u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_sin(cfg_sin), .cfg_shift(cfg_shift),
        .cfg_load(cfg_load), .x_in(x_in), .y_out(y_out), .cfg_sout(cfg_sout)
    );

    // Reference model: shift history queue and active bitmap.
    bit hist[$];
    bit act[W];

    function automatic bit stage_bit(int k);
        int n;
        n = hist.size();
        if (k < n) return hist[n-1-k];
        return 1'b0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            hist.delete();
            for (int k = 0; k < W; k++) act[k] = 1'b0;
        end else begin
            if (cfg_load)
                for (int k = 0; k < W; k++) act[k] = stage_bit(k);
            if (cfg_shift) begin
                hist.push_back(cfg_sin);
                if (hist.size() > W) void'(hist.pop_front());
            end
        end
    end

    function automatic logic [NO-1:0] ref_eval(logic [NI-1:0] x);
        logic [NO-1:0] r;
        bit tv[NT];
        bit used;
        bit ok;
        bit s;
        for (int t = 0; t < NT; t++) begin
            used = 0;
            ok = 1;
            for (int j = 0; j < AW; j++) begin
                if (act[W - AW*(t+1) + j]) begin
                    used = 1;
                    if ((j % 2) == 0 && !x[j/2]) ok = 0;
                    if ((j % 2) == 1 && x[j/2]) ok = 0;
                end
            end
            tv[t] = used && ok;
        end
        for (int o = 0; o < NO; o++) begin
            s = 0;
            for (int t = 0; t < NT; t++)
                if (act[NO + NT*(NO-1-o) + t] && tv[t]) s = 1;
            r[o] = s ^ act[o];
        end
        return r;
    endfunction

    task automatic chk(string req, logic [31:0] actual, logic [31:0] expected);
        checks++;
        if (actual !== expected) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
        end
    endtask

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            chk(cur_req, {29'd0, y_out}, {29'd0, ref_eval(x_in)});
            chk("R2", {31'd0, cfg_sout}, {31'd0, stage_bit(W-1)});
        end
    end

    task automatic tick;
        @(negedge clk);
        #1;
    endtask

    task automatic send(logic [W-1:0] v);
        for (int k = W - 1; k >= 0; k--) begin
            tick();
            cfg_shift = 1'b1;
            cfg_sin = v[k];
        end
        tick();
        cfg_shift = 1'b0;
        cfg_sin = 1'b0;
    endtask

    task automatic load_cfg;
        tick();
        cfg_load = 1'b1;
        tick();
        cfg_load = 1'b0;
    endtask

    task automatic try_x(logic [NI-1:0] x, logic [NO-1:0] exp_y, string req);
        tick();
        x_in = x;
        #1;
        chk(req, {29'd0, y_out}, {29'd0, exp_y});
    endtask

    logic [W-1:0] cfg_a;
    logic [W-1:0] cfg_b;

    task automatic finish_run;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        // A: t0=x0&~x1, t1=x0&x2, t2=~x1&x2, t3 empty; y0=t0|t1, y1=t1|t2, y2=t3 inverted
        cfg_a = {6'b001001, 6'b010001, 6'b011000, 6'b000000,
                 4'b0011, 4'b0110, 4'b1000, 3'b100};
        // B: t0=x0&~x0, t1=x1; y0=t0, y1=~t1, y2 unattached
        cfg_b = {6'b000011, 6'b000100, 6'b000000, 6'b000000,
                 4'b0001, 4'b0010, 4'b0000, 3'b010};

        repeat (3) tick();
        rst_n = 1'b1;
        cur_req = "R1";
        try_x(3'b111, 3'b000, "R1");
        chk("R1", {31'd0, cfg_sout}, 32'd0);

        // R10: staging A alone leaves outputs at zero
        cur_req = "R10";
        x_in = 3'b101;
        send(cfg_a);
        chk("R10", {29'd0, y_out}, 32'd0);

        cur_req = "R4";
        load_cfg();
        try_x(3'b000, 3'b100, "R6");
        try_x(3'b001, 3'b101, "R5");
        try_x(3'b101, 3'b111, "R7");
        try_x(3'b100, 3'b110, "R4");
        try_x(3'b011, 3'b100, "R8");
        try_x(3'b111, 3'b111, "R7");

        // R2 readback of staged A while shifting zeros
        cur_req = "R10";
        for (int k = 0; k < W; k++) begin
            tick();
            chk("R2", {31'd0, cfg_sout}, {31'd0, cfg_a[W-1-k]});
            cfg_shift = 1'b1;
            cfg_sin = 1'b0;
        end
        tick();
        cfg_shift = 1'b0;
        try_x(3'b101, 3'b111, "R10");

        // R3: stage B, then load and shift in the same cycle
        send(cfg_b);
        try_x(3'b001, 3'b101, "R10");
        cur_req = "R3";
        tick();
        cfg_load = 1'b1;
        cfg_shift = 1'b1;
        cfg_sin = 1'b1;
        tick();
        cfg_load = 1'b0;
        cfg_shift = 1'b0;
        cfg_sin = 1'b0;
        try_x(3'b001, 3'b010, "R3");
        try_x(3'b000, 3'b010, "R6");
        try_x(3'b010, 3'b000, "R8");
        try_x(3'b111, 3'b000, "R3");

        // R9: combinational response within one cycle
        cur_req = "R9";
        tick();
        x_in = 3'b010;
        #1;
        chk("R9", {29'd0, y_out}, 32'd0);
        x_in = 3'b000;
        #1;
        chk("R9", {29'd0, y_out}, 32'd2);

        repeat (2) tick();
        finish_run();
    end
endmodule